// File: doc/BRIEF.md
# Direct-Mapped Split-Permission Translation Cache

This block caches virtual-to-physical page translations in a direct-mapped array. Each slot has one physical page number, and three tags sit beside it. The fetch path, the load path and the store path each have their own tag, so a translation can be valid for one kind of access and not for another. The slot is chosen by the low bits of the virtual page number. Each tag holds the whole virtual page number, so two pages that land on the same slot are always told apart.

A lookup is combinational. It takes a virtual address and an access kind and returns a hit flag and a physical address. The physical address is the stored page number joined to the page offset of the request. A refill writes the new page number into the shared slot and writes the tag of its own access kind. In the same edge it clears any sibling tag that names a different page. A sibling tag that already names the same page is kept. A flush clears every tag in one edge and takes priority over a refill in the same cycle. The design has no state machine: all of its state is the tag and data arrays.

Top module: `dm_split_tlb`

## Requirements
- R1: The slot is picked by virtual address bits [OFF_W +: log2(ENTRIES)]. The tag holds the full virtual page number, so a page with the same slot bits but different upper bits misses.
- R2: The access kind is encoded as 2'b00 fetch, 2'b01 load, 2'b10 store and 2'b11 reserved. A lookup hits only when the tag of the requested kind holds the requested page. A reserved-kind lookup always misses, and a reserved-kind refill writes no tag.
- R3: On a hit, lk_paddr is {stored physical page, lk_vaddr[OFF_W-1:0]}, with the page offset passed through unchanged.
- R4: A refill (rf_en high, flush low) writes its kind's tag and the shared page number on the clock edge. A lookup in the following cycle hits with the new page.
- R5: A refill leaves alone any sibling tag that already holds the refilled page. That sibling then hits with the newly written physical page.
- R6: A refill clears every sibling tag at its slot that holds a different page, so those lookups miss afterwards.
- R7: A flush clears all tags of all kinds. No lookup hits in the cycle after a flush.
- R8: When flush and rf_en are high in the same cycle, the flush wins and the refill leaves no valid tag.
- R9: After reset every tag is invalid and no lookup hits.
- R10: The all-ones virtual page number is the invalid marker. A lookup of it never hits, even after a refill of that page.
- R11: A refill at one slot does not change the contents of any other slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all tags |
| lk_vaddr | input | VPN_W+OFF_W | Lookup virtual address |
| lk_type | input | 2 | Lookup access kind |
| lk_hit | output | 1 | Lookup hit |
| lk_paddr | output | PPN_W+OFF_W | Lookup physical address |
| rf_en | input | 1 | Refill strobe |
| rf_vaddr | input | VPN_W+OFF_W | Refill virtual address |
| rf_type | input | 2 | Refill access kind |
| rf_ppn | input | PPN_W | Refill physical page number |

## Verification
Lookups are made with the same page under each of the three kinds and with a second page that lands on the same slot. Together these separate a per-kind tag from a shared one, and a full-page tag from one that keeps only the upper bits. Refills are sequenced so that a sibling tag either matches the new page or differs from it. The following lookups show whether a sibling is kept or cleared, and whether the shared slot was rewritten. Further refills touch a neighbouring slot, use the reserved kind, collide with a flush in the same cycle and use the all-ones page. Each of these cases can only be seen through a hit or a miss on a later lookup.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    localparam int NUM_KINDS = 3;
endpackage

// File: rtl/tlb_addr_split.sv
module tlb_addr_split #(
    parameter int VPN_W = 20,
    parameter int OFF_W = 12,
    parameter int IDX_W = 4
) (
    input  logic [VPN_W+OFF_W-1:0] vaddr,
    output logic [VPN_W-1:0]       vpn,
    output logic [IDX_W-1:0]       idx,
    output logic [OFF_W-1:0]       off
);
    assign vpn = vaddr[VPN_W+OFF_W-1:OFF_W];
    assign idx = vaddr[OFF_W +: IDX_W];
    assign off = vaddr[OFF_W-1:0];
endmodule

// File: rtl/tlb_tag_bank.sv
module tlb_tag_bank #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4,
    parameter int VPN_W   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             rf_en,
    input  logic             rf_own,
    input  logic [IDX_W-1:0] rf_idx,
    input  logic [VPN_W-1:0] rf_vpn,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [VPN_W-1:0] rd_tag
);
    logic [VPN_W-1:0] tag_q [ENTRIES];

    // all-ones is the invalid marker
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) tag_q[i] <= '1;
        end else if (flush) begin
            for (int i = 0; i < ENTRIES; i++) tag_q[i] <= '1;
        end else if (rf_en) begin
            if (rf_own)
                tag_q[rf_idx] <= rf_vpn;
            else if (tag_q[rf_idx] != rf_vpn)
                tag_q[rf_idx] <= '1;
        end
    end

    assign rd_tag = tag_q[rd_idx];
endmodule

// File: rtl/tlb_data_bank.sv
module tlb_data_bank #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4,
    parameter int PPN_W   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [PPN_W-1:0] rd_ppn
);
    logic [PPN_W-1:0] ppn_q [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ppn_q[i] <= '0;
        end else if (wr_en) begin
            ppn_q[wr_idx] <= wr_ppn;
        end
    end

    assign rd_ppn = ppn_q[rd_idx];
endmodule

// File: rtl/dm_split_tlb.sv
module dm_split_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int OFF_W   = 12,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int VADDR_W = VPN_W + OFF_W,
    localparam int PADDR_W = PPN_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [VADDR_W-1:0] lk_vaddr,
    input  logic [1:0]         lk_type,
    output logic               lk_hit,
    output logic [PADDR_W-1:0] lk_paddr,
    input  logic               rf_en,
    input  logic [VADDR_W-1:0] rf_vaddr,
    input  logic [1:0]         rf_type,
    input  logic [PPN_W-1:0]   rf_ppn
);
    logic [VPN_W-1:0] lk_vpn, rf_vpn;
    logic [IDX_W-1:0] lk_idx, rf_idx;
    logic [OFF_W-1:0] lk_off, rf_off_unused;
    logic [VPN_W-1:0] kind_tag [NUM_KINDS];
    logic [PPN_W-1:0] slot_ppn;
    logic [VPN_W-1:0] sel_tag;
    logic             sel_ok;

    tlb_addr_split #(.VPN_W(VPN_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_lk_split (
        .vaddr(lk_vaddr), .vpn(lk_vpn), .idx(lk_idx), .off(lk_off)
    );

    tlb_addr_split #(.VPN_W(VPN_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_rf_split (
        .vaddr(rf_vaddr), .vpn(rf_vpn), .idx(rf_idx), .off(rf_off_unused)
    );

    for (genvar g = 0; g < NUM_KINDS; g++) begin : g_kind
        logic own;
        assign own = (rf_type == 2'(g));
        tlb_tag_bank #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .VPN_W(VPN_W)) u_tags (
            .clk    (clk),
            .rst_n  (rst_n),
            .flush  (flush),
            .rf_en  (rf_en),
            .rf_own (own),
            .rf_idx (rf_idx),
            .rf_vpn (rf_vpn),
            .rd_idx (lk_idx),
            .rd_tag (kind_tag[g])
        );
    end

    tlb_data_bank #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .PPN_W(PPN_W)) u_data (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (rf_en && !flush),
        .wr_idx (rf_idx),
        .wr_ppn (rf_ppn),
        .rd_idx (lk_idx),
        .rd_ppn (slot_ppn)
    );

    always_comb begin
        sel_tag = '1;
        sel_ok  = 1'b0;
        unique case (acc_e'(lk_type))
            ACC_FETCH: begin sel_tag = kind_tag[0]; sel_ok = 1'b1; end
            ACC_LOAD:  begin sel_tag = kind_tag[1]; sel_ok = 1'b1; end
            ACC_STORE: begin sel_tag = kind_tag[2]; sel_ok = 1'b1; end
            ACC_RSVD:  begin sel_tag = '1;          sel_ok = 1'b0; end
        endcase
    end

    assign lk_hit   = sel_ok && (sel_tag == lk_vpn) && (lk_vpn != '1);
    assign lk_paddr = {slot_ppn, lk_off};
endmodule

// File: rtl/dm_split_tlb_chk.sv
module dm_split_tlb_chk #(
    parameter int VPN_W = 20,
    parameter int PPN_W = 20,
    parameter int OFF_W = 12,
    localparam int VADDR_W = VPN_W + OFF_W,
    localparam int PADDR_W = PPN_W + OFF_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush,
    input logic [VADDR_W-1:0] lk_vaddr,
    input logic [1:0]         lk_type,
    input logic               lk_hit,
    input logic [PADDR_W-1:0] lk_paddr,
    input logic               rf_en,
    input logic [VADDR_W-1:0] rf_vaddr,
    input logic [1:0]         rf_type,
    input logic [PPN_W-1:0]   rf_ppn
);
    // R7
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit);

    // R2
    rsvd_kind_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_type == 2'd3) |-> !lk_hit);

    // R10
    ones_page_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_vaddr[VADDR_W-1:OFF_W] == '1) |-> !lk_hit);

    // R9
    reset_empty_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> !lk_hit);

    // R4
    refill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rf_en) && !$past(flush) && ($past(rf_type) != 2'd3)
         && ($past(rf_vaddr[VADDR_W-1:OFF_W]) != '1)
         && (lk_vaddr[VADDR_W-1:OFF_W] == $past(rf_vaddr[VADDR_W-1:OFF_W]))
         && (lk_type == $past(rf_type)))
        |-> (lk_hit && (lk_paddr[PADDR_W-1:OFF_W] == $past(rf_ppn))));
endmodule

bind dm_split_tlb dm_split_tlb_chk #(.VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lk_vaddr(lk_vaddr), .lk_type(lk_type),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr), .rf_en(rf_en), .rf_vaddr(rf_vaddr),
    .rf_type(rf_type), .rf_ppn(rf_ppn)
);

// File: tb/dm_split_tlb_test.sv
`timescale 1ns/1ps
module dm_split_tlb_test;
    localparam int VPN_W = 20;
    localparam int PPN_W = 20;
    localparam int OFF_W = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [1:0]  lk_type = 2'd0;
    logic        lk_hit;
    logic [31:0] lk_paddr;
    logic        rf_en = 1'b0;
    logic [31:0] rf_vaddr = '0;
    logic [1:0]  rf_type = 2'd0;
    logic [19:0] rf_ppn = '0;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    dm_split_tlb #(.ENTRIES(16), .VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) uut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .lk_vaddr(lk_vaddr), .lk_type(lk_type),
        .lk_hit(lk_hit), .lk_paddr(lk_paddr), .rf_en(rf_en), .rf_vaddr(rf_vaddr),
        .rf_type(rf_type), .rf_ppn(rf_ppn)
    );

    typedef struct packed {
        logic        is_refill;
        logic [1:0]  kind;
        logic [19:0] vpn;
        logic [11:0] off;
        logic [19:0] ppn;
        logic        exp_hit;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd1, 20'h00005, 12'h123, 20'h00000, 1'b0, 4'd9},  // R9 empty after reset
        '{1'b1, 2'd1, 20'h00005, 12'h000, 20'hABCDE, 1'b0, 4'd4},  // R4 load refill
        '{1'b0, 2'd1, 20'h00005, 12'h123, 20'hABCDE, 1'b1, 4'd3},  // R3 hit, offset kept
        '{1'b0, 2'd0, 20'h00005, 12'h123, 20'h00000, 1'b0, 4'd2},  // R2 fetch tag separate
        '{1'b0, 2'd2, 20'h00005, 12'h123, 20'h00000, 1'b0, 4'd2},  // R2 store tag separate
        '{1'b0, 2'd1, 20'h00015, 12'h123, 20'h00000, 1'b0, 4'd1},  // R1 alias same slot
        '{1'b1, 2'd0, 20'h00005, 12'h000, 20'h11111, 1'b0, 4'd5},  // R5 fetch refill same page
        '{1'b0, 2'd1, 20'h00005, 12'h456, 20'h11111, 1'b1, 4'd5},  // R5 load kept, new data
        '{1'b0, 2'd0, 20'h00005, 12'hFFF, 20'h11111, 1'b1, 4'd4},  // R4 fetch hits
        '{1'b1, 2'd2, 20'h00015, 12'h000, 20'h22222, 1'b0, 4'd6},  // R6 store refill other page
        '{1'b0, 2'd1, 20'h00005, 12'h001, 20'h00000, 1'b0, 4'd6},  // R6 load cleared
        '{1'b0, 2'd0, 20'h00005, 12'h001, 20'h00000, 1'b0, 4'd6},  // R6 fetch cleared
        '{1'b0, 2'd2, 20'h00015, 12'h7A0, 20'h22222, 1'b1, 4'd4},  // R4 store hits
        '{1'b1, 2'd1, 20'h00006, 12'h000, 20'h33333, 1'b0, 4'd11}, // R11 refill next slot
        '{1'b0, 2'd2, 20'h00015, 12'h0F0, 20'h22222, 1'b1, 4'd11}, // R11 slot 5 untouched
        '{1'b0, 2'd1, 20'h00006, 12'h000, 20'h33333, 1'b1, 4'd4},  // R4 slot 6 hits
        '{1'b0, 2'd3, 20'h00006, 12'h000, 20'h00000, 1'b0, 4'd2},  // R2 reserved kind misses
        '{1'b1, 2'd3, 20'h00006, 12'h000, 20'h44444, 1'b0, 4'd2},  // R2 reserved refill
        '{1'b0, 2'd1, 20'h00006, 12'h010, 20'h44444, 1'b1, 4'd5},  // R5 matching load tag kept
        '{1'b0, 2'd0, 20'h00006, 12'h010, 20'h00000, 1'b0, 4'd2}   // R2 no tag written
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic refill(input logic [1:0] kind, input logic [19:0] vpn,
                          input logic [19:0] ppn, input bit with_flush);
        @(negedge clk);
        rf_en = 1'b1; rf_type = kind; rf_vaddr = {vpn, 12'h000}; rf_ppn = ppn;
        flush = with_flush;
        @(negedge clk);
        rf_en = 1'b0; flush = 1'b0;
    endtask

    task automatic lookup(input logic [1:0] kind, input logic [19:0] vpn, input logic [11:0] off,
                          input bit exp_hit, input logic [19:0] exp_ppn, input string req);
        @(negedge clk);
        lk_type = kind; lk_vaddr = {vpn, off};
        #1;
        check(lk_hit == exp_hit, req, "hit", 32'(lk_hit), 32'(exp_hit));
        if (exp_hit)
            check(lk_paddr == {exp_ppn, off}, req, "paddr", lk_paddr, {exp_ppn, off});
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog all requirements actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(lk_hit == 1'b0, "R9", "hit in reset", 32'(lk_hit), 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_refill)
                refill(VECS[i].kind, VECS[i].vpn, VECS[i].ppn, 1'b0);
            else
                lookup(VECS[i].kind, VECS[i].vpn, VECS[i].off, VECS[i].exp_hit,
                       VECS[i].ppn, $sformatf("R%0d", VECS[i].req));
        end

        // R7: flush clears every kind
        refill(2'd0, 20'h00009, 20'h55555, 1'b0);
        lookup(2'd0, 20'h00009, 12'h000, 1'b1, 20'h55555, "R7");
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        lookup(2'd0, 20'h00009, 12'h000, 1'b0, 20'h0, "R7");
        lookup(2'd2, 20'h00015, 12'h000, 1'b0, 20'h0, "R7");

        // R8: flush beats a refill in the same cycle
        refill(2'd1, 20'h00007, 20'h66666, 1'b1);
        lookup(2'd1, 20'h00007, 12'h000, 1'b0, 20'h0, "R8");

        // R10: the all-ones page never hits
        refill(2'd1, 20'hFFFFF, 20'h77777, 1'b0);
        lookup(2'd1, 20'hFFFFF, 12'h000, 1'b0, 20'h0, "R10");

        // R9: reset mid-run clears a valid entry
        refill(2'd2, 20'h00003, 20'h88888, 1'b0);
        lookup(2'd2, 20'h00003, 12'h000, 1'b1, 20'h88888, "R9");
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        lookup(2'd2, 20'h00003, 12'h000, 1'b0, 20'h0, "R9");

        finish_run();
    end
endmodule